// File: doc/BRIEF.md
# Indirect-Address MDIO Management Engine

This block runs the management-bus transactions a host needs to reach registers inside a physical-layer device that uses indirect addressing. The host sets the command fields (16-bit register address, 5-bit device type, 5-bit port address and 2-bit opcode) and pulses `cmdWrite` with the go bit `cmdGo` raised. The engine then reports `busy` until the frame has left the bus. A full access takes two steps. An address frame first loads the register address into the device. A read or write frame to the same port and device then follows.

Write data is placed in the low half of the data register before the commands are issued. When a read frame completes, the 16 bits captured from the device appear in the high half of the same register. The management clock is the system clock divided by a half-period count that the host chooses. The serial line is driven through a tristate output enable, and that enable is released while a read frame's turnaround and data are on the bus.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset `busy`, `mdc` and `mdioOe` are 0, `mdioOut` is 1 and `dataReg` is all zero.
- R2: Each frame is 64 bits sent MSB first: 32 ones, then `00`, the 2-bit opcode, the 5-bit port address and the 5-bit device type (each MSB first), then a turnaround of `10`, then 16 payload bits. The payload is the register address for an address frame and `dataReg[15:0]` for a write frame.
- R3: The opcodes are 00 for an address frame, 01 for a write frame and 11 for a read frame. A command with opcode 10 is ignored and starts no frame.
- R4: A command accepted at a clock edge raises `busy` at that edge. `mdc` has a half-period of D system clocks, where D is `divHalf` latched at acceptance and a value of 0 acts as 1. `busy` stays high for exactly 128·D clocks, and `mdc` is low while idle.
- R5: `mdioOut` changes only on falling `mdc` edges. The device's read bits are sampled on rising `mdc` edges.
- R6: `mdioOe` is high from acceptance until the frame ends. On read frames it is low for frame bits 46 to 63, which are the turnaround and data. It is low while idle.
- R7: When a read frame completes, `dataReg[31:16]` holds the 16 sampled bits, the first sampled bit being the MSB. `dataReg[15:0]` keeps the value last written through `dataWrite`. Address and write frames leave `dataReg[31:16]` unchanged.
- R8: A command presented while `busy` is high is ignored. The frame in progress is unchanged and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWrite | input | 1 | Command register write strobe |
| cmdGo | input | 1 | Go/busy bit of the written command |
| cmdOp | input | 2 | Opcode: 00 address, 01 write, 11 read |
| cmdPortAddr | input | 5 | Port address field |
| cmdDevType | input | 5 | Device type field |
| cmdRegAddr | input | 16 | Register address carried by address frames |
| dataWrite | input | 1 | Write strobe for the low half of the data register |
| dataWrIn | input | 16 | Write data for the low half |
| divHalf | input | DIV_W | MDC half-period in system clocks |
| busy | output | 1 | Command bit; clears when the frame ends |
| dataReg | output | 32 | Read data in [31:16], write data in [15:0] |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data out |
| mdioOe | output | 1 | Output enable for the serial line |
| mdioIn | input | 1 | Serial data in |

## Verification
The bench behaves as the device. It records every bit at rising `mdc` edges and answers read frames after falling edges. It sweeps all three opcodes over several divider values, including 0, and several field patterns. An off-by-one in the bit counter would shift the whole frame or shorten `busy` by 2·D clocks. An output enable released one bit late or early would show up in the turnaround positions of read frames. A design that sampled on the wrong edge, or assembled the captured bits LSB first, would return bit-reversed or shifted read data. The bench also fires a second command in the middle of a frame and a command with opcode 10. A design that does not block these would corrupt the frame or start an extra one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_BIT   = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA_BIT     = IDX_W'(FRAME_BITS - REG_W - 2);
  localparam logic [IDX_W-1:0] DATA_BIT   = IDX_W'(FRAME_BITS - REG_W);

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_BAD   = 2'b10,
    OP_READ  = 2'b11
  } mdioOp_e;

  typedef struct packed {
    logic load;     // command accepted, build frame
    logic advance;  // falling MDC: move to next bit
    logic sample;   // rising MDC inside data field
    logic finish;   // falling MDC after last bit
    logic enterTa;  // advance lands on the turnaround
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic             cmdGo,
  input  logic [1:0]       cmdOp,
  input  logic [DIV_W-1:0] divHalf,
  output logic             busy,
  output logic             mdc,
  output mdioStrobe_t      stb
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [IDX_W-1:0] bitIdx;
  logic accept;
  logic tick;

  assign accept = cmdWrite && cmdGo && !busy && (cmdOp != OP_BAD);
  assign tick   = busy && (divCnt == divLat - DIV_W'(1));

  always_comb begin
    stb         = '0;
    stb.load    = accept;
    stb.sample  = tick && !mdc && (bitIdx >= DATA_BIT);
    stb.advance = tick && mdc && (bitIdx != LAST_BIT);
    stb.finish  = tick && mdc && (bitIdx == LAST_BIT);
    stb.enterTa = stb.advance && (bitIdx == TA_BIT - IDX_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      divLat <= DIV_W'(1);
      bitIdx <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      divLat <= (divHalf == '0) ? DIV_W'(1) : divHalf;
      bitIdx <= '0;
    end else if (tick) begin
      divCnt <= '0;
      mdc    <= !mdc;
      if (mdc) begin
        if (bitIdx == LAST_BIT) busy <= 1'b0;
        else bitIdx <= bitIdx + IDX_W'(1);
      end
    end else if (busy) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  p_idle_mdc_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  p_finish_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (!busy && !mdc));
  p_sample_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |=> mdc);
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish) |=> (busy && $stable(divLat)));
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       stb,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdPortAddr,
  input  logic [ADDR_W-1:0] cmdDevType,
  input  logic [REG_W-1:0]  cmdRegAddr,
  input  logic              dataWrite,
  input  logic [REG_W-1:0]  dataWrIn,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [2*REG_W-1:0] dataReg
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameNext;
  logic [REG_W-1:0]      payload;
  logic [REG_W-1:0]      capture;
  logic                  readOp;

  always_comb begin
    unique case (cmdOp)
      OP_ADDR:  payload = cmdRegAddr;
      OP_WRITE: payload = dataReg[REG_W-1:0];
      default:  payload = '1;
    endcase
    frameNext = {{(FRAME_BITS-REG_W-2*ADDR_W-6){1'b1}}, 2'b00, cmdOp,
                 cmdPortAddr, cmdDevType, 2'b10, payload};
  end

  assign mdioOut = shiftReg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      capture  <= '0;
      readOp   <= 1'b0;
      mdioOe   <= 1'b0;
      dataReg  <= '0;
    end else begin
      if (stb.load) begin
        shiftReg <= frameNext;
        readOp   <= (cmdOp == OP_READ);
        mdioOe   <= 1'b1;
      end else if (stb.finish) begin
        shiftReg <= '1;
        mdioOe   <= 1'b0;
      end else if (stb.advance) begin
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b1};
        if (stb.enterTa && readOp) mdioOe <= 1'b0;
      end
      if (stb.sample) capture <= {capture[REG_W-2:0], mdioIn};
      if (stb.finish && readOp) dataReg[2*REG_W-1:REG_W] <= capture;
      if (dataWrite) dataReg[REG_W-1:0] <= dataWrIn;
    end
  end

  p_out_hold_at_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.sample |=> $stable(mdioOut));
  p_oe_on_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> mdioOe);
  p_oe_off_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> !mdioOe);
  p_upper_only_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataReg[2*REG_W-1:REG_W]) |-> $past(stb.finish && readOp));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic             cmdGo,
  input  logic [1:0]       cmdOp,
  input  logic [4:0]       cmdPortAddr,
  input  logic [4:0]       cmdDevType,
  input  logic [15:0]      cmdRegAddr,
  input  logic             dataWrite,
  input  logic [15:0]      dataWrIn,
  input  logic [DIV_W-1:0] divHalf,
  output logic             busy,
  output logic [31:0]      dataReg,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);
  mdioStrobe_t stb;

  mdio_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdGo(cmdGo),
    .cmdOp(cmdOp), .divHalf(divHalf), .busy(busy), .mdc(mdc), .stb(stb)
  );

  mdio_dpath uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdOp(cmdOp),
    .cmdPortAddr(cmdPortAddr), .cmdDevType(cmdDevType),
    .cmdRegAddr(cmdRegAddr), .dataWrite(dataWrite), .dataWrIn(dataWrIn),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe), .dataReg(dataReg)
  );
endmodule

// File: tb/tb_mdio_cmd_engine.sv
`timescale 1ns/100ps
module tb_mdio_cmd_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrite = 1'b0, cmdGo = 1'b0, dataWrite = 1'b0, mdioIn = 1'b1;
  logic [1:0] cmdOp = 2'b00;
  logic [4:0] cmdPortAddr = '0, cmdDevType = '0;
  logic [15:0] cmdRegAddr = '0, dataWrIn = '0;
  logic [7:0] divHalf = 8'd1;
  logic busy, mdc, mdioOut, mdioOe;
  logic [31:0] dataReg;

  int vectors = 0, fails = 0, posCount = 0;
  bit doneFlag = 0;
  logic [63:0] gotBits, gotOe;
  logic [15:0] rdResp = '0;

  always #2.5 clk = ~clk;

  mdio_cmd_engine dut (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdGo(cmdGo), .cmdOp(cmdOp),
    .cmdPortAddr(cmdPortAddr), .cmdDevType(cmdDevType), .cmdRegAddr(cmdRegAddr),
    .dataWrite(dataWrite), .dataWrIn(dataWrIn), .divHalf(divHalf), .busy(busy),
    .dataReg(dataReg), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  // Device model: record on rising MDC, answer after falling MDC.
  always @(posedge mdc) begin
    if (posCount < 64) begin
      gotBits[63-posCount] = mdioOut;
      gotOe[63-posCount]   = mdioOe;
    end
    posCount = posCount + 1;
  end
  always @(negedge mdc) begin
    if (posCount >= 48 && posCount < 64) mdioIn = rdResp[63-posCount];
    else mdioIn = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic runFrame(input int d, input logic [1:0] op, input int k,
                          input bit inject, inout logic [15:0] expUpper);
    logic [4:0] port, dev;
    logic [15:0] ra, wd;
    logic [63:0] expF, mask, expOe;
    int dEff, cnt;
    port = 5'((k * 7 + d * 3 + int'(op)) & 31);
    dev  = 5'((k * 11 + d + 5) & 31);
    ra   = 16'hA5C3 ^ 16'(k * 16'h1357 + d * 16'h0F0F);
    wd   = 16'h3C96 ^ 16'(k * 16'h2468 + d);
    dEff = (d == 0) ? 1 : d;
    @(negedge clk);
    dataWrite = 1'b1; dataWrIn = wd;
    rdResp = 16'h8001 ^ 16'(k * 16'h5A5A + d * 16'h0333);
    @(negedge clk);
    dataWrite = 1'b0;
    posCount = 0;
    divHalf = 8'(d);
    cmdOp = op; cmdPortAddr = port; cmdDevType = dev; cmdRegAddr = ra;
    cmdWrite = 1'b1; cmdGo = 1'b1;
    @(posedge clk);
    cnt = 0;
    forever begin
      @(negedge clk);
      cmdWrite = 1'b0;
      if (!busy || cnt > 100000) break;
      cnt++;
      if (inject && cnt == 10) begin  // R8: second command mid-frame
        cmdWrite = 1'b1; cmdOp = 2'b11 ^ op; cmdPortAddr = ~port;
        cmdRegAddr = ~ra; divHalf = 8'd5;
      end
    end
    // R4: busy length
    chk(cnt == 128 * dEff, "R4 busy cycles", 64'(cnt), 64'(128 * dEff));
    repeat (8 * dEff) @(negedge clk);
    // R8: exactly one frame, engine idle afterwards
    chk(posCount == 64 && !busy, "R8 single frame", 64'(posCount), 64'd64);
    // R2/R3/R5: frame contents sampled at rising MDC
    expF = {32'hFFFFFFFF, 2'b00, op, port, dev, 2'b10,
            (op == 2'b00) ? ra : (op == 2'b01) ? wd : 16'hFFFF};
    mask  = (op == 2'b11) ? {{46{1'b1}}, {18{1'b0}}} : '1;
    expOe = mask;
    chk((gotBits & mask) == (expF & mask), "R2 frame bits",
        gotBits & mask, expF & mask);
    // R6: output enable per bit
    chk(gotOe == expOe, "R6 output enable", gotOe, expOe);
    // R7: data register halves
    if (op == 2'b11) expUpper = rdResp;
    chk(dataReg == {expUpper, wd}, "R7 data register", 64'(dataReg),
        64'({expUpper, wd}));
  endtask

  initial begin
    logic [15:0] expUpper;
    expUpper = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !mdc && !mdioOe && mdioOut && dataReg == '0, "R1 reset state",
        {59'd0, busy, mdc, mdioOe, mdioOut, |dataReg}, 64'b0010);
    // R3: opcode 10 ignored
    posCount = 0;
    cmdOp = 2'b10; cmdWrite = 1'b1; cmdGo = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && posCount == 0 && !mdioOe, "R3 opcode 10 ignored",
        64'(posCount) | {63'd0, busy}, 64'd0);
    // Go bit low: no frame
    cmdOp = 2'b00; cmdWrite = 1'b1; cmdGo = 1'b0;
    @(negedge clk);
    cmdWrite = 1'b0;
    repeat (10) @(negedge clk);
    chk(!busy && posCount == 0, "R4 go bit required", 64'(busy), 64'd0);
    // Sweep dividers, opcodes, field patterns
    for (int d = 0; d < 4; d++)
      for (int o = 0; o < 3; o++)
        for (int k = 0; k < 2; k++)
          runFrame(d, (o == 0) ? 2'b00 : (o == 1) ? 2'b01 : 2'b11, k,
                   k == 1, expUpper);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule